// File: doc/BRIEF.md
# Cartridge Bank and Interval-Interrupt Controller

This block is the CPU-facing control logic of a game cartridge. It catches CPU writes to the upper half of the address space and files each data byte into one of sixteen 8-bit control registers. The register is chosen by a nibble of the address. Bank numbers and chip selects for program ROM, work RAM and character memory come straight from those registers, along with the nametable mirroring bit.

The program space is split into four 8 KB windows. The first three can each point at either the internal or the external ROM chip. The topmost window is always tied to the final bank of the external chip, so the system can boot from it. Work RAM is seen through two 4 KB windows. Each of their bank numbers folds the register's lowest bit into its upper bits.

A 16-bit up-counter raises a level interrupt to the CPU when it wraps. Software sets a reload latch, starts the counter with an enable and a saved enable, and acknowledges the interrupt. On acknowledgement the enable is restored from the saved copy, so one command both clears the request and chooses whether counting goes on.

Top module: `cart_bank_irq_ctrl`

## Requirements
- R1: A CPU write with address bit 15 set stores the data byte in register number addr[11:8]. The other address bits have no effect on which register is written.
- R2: Work-RAM window k (k = 0 for 0x6000, 1 for 0x7000) takes its bank from register k as (r >> 2) | (r & 1), 6 bits wide, on `wram_bank_o[6k+5:6k]`.
- R3: Program window k for k = 0..2 (0x8000, 0xA000, 0xC000) is driven by register 2+k. Bits 5:0 form the bank on `prg_bank_o[6k+5:6k]`, and bit 6 drives `prg_ext_o[k]` (1 = external chip). Bit 7 is ignored.
- R4: Program window 3 (0xE000) always selects the external chip and bank 0x3F.
- R5: `mirror_o` is the inverse of register 10 bit 1.
- R6: `chr_page_lo_o` equals register 5 bit 0, and `chr_page_hi_o` is always 1.
- R7: A write to exactly 0xD600 loads the low byte of the 16-bit reload latch. A write to exactly 0xD700 loads the high byte.
- R8: A write to exactly 0xD900 copies the latch into the counter. It sets the enable from data bit 1 and the saved enable from data bit 0, and clears the pending interrupt.
- R9: A write to exactly 0xD800 clears the pending interrupt and copies the saved enable into the enable.
- R10: While enabled, the counter advances by one per clock. A step from 0xFFFF reloads it from the latch and sets `irq_o`. `irq_o` stays high until a 0xD800 or 0xD900 write.
- R11: Writes with address bit 15 clear leave every register and output unchanged.
- R12: After reset all registers are zero and the interrupt is idle: work-RAM banks 0, windows 0..2 internal bank 0, mirror 1, `chr_page_lo_o` 0, `irq_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock; one counter step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Write strobe, one cycle per CPU write |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_wdata | input | 8 | CPU write data |
| wram_bank_o | output | 12 | Two 6-bit work-RAM bank numbers, window 0 in the low bits |
| prg_bank_o | output | 24 | Four 6-bit program bank numbers, window 0 in the low bits |
| prg_ext_o | output | 4 | Per program window: 1 selects the external ROM chip |
| chr_page_lo_o | output | 1 | Character page for the 0x0000 half |
| chr_page_hi_o | output | 1 | Character page for the 0x1000 half |
| mirror_o | output | 1 | Nametable mirroring select |
| irq_o | output | 1 | Level interrupt request to the CPU |

## Verification
The assertions assume that `cpu_wr` is a single-cycle pulse with address and data valid in the same cycle. They also assume that no acknowledge write lands in the same cycle as a counter wrap, because there the new request takes priority. The bench drives each write for exactly one clock, between falling edges. It only acknowledges while the counter is at least two steps from wrapping, which keeps every command clear of a wrap edge.

// File: rtl/cbic_pkg.sv
package cbic_pkg;
    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int NREG        = 16;
    localparam int IDX_W       = $clog2(NREG);
    localparam int IDX_LSB     = 8;
    localparam int PRG_WIN     = 4;
    localparam int PRG_BANK_W  = 6;
    localparam int PRG_CHIP_B  = PRG_BANK_W;
    localparam int WRAM_WIN    = 2;
    localparam int WRAM_BANK_W = DATA_W - 2;
    localparam int CNT_W       = 2 * DATA_W;

    localparam int REG_WRAM0   = 0;
    localparam int REG_PRG0    = 2;
    localparam int REG_CHR     = 5;
    localparam int REG_MIRROR  = 10;

    localparam logic [ADDR_W-1:0] ADR_LATCH_LO = 16'hD600;
    localparam logic [ADDR_W-1:0] ADR_LATCH_HI = 16'hD700;
    localparam logic [ADDR_W-1:0] ADR_ACK      = 16'hD800;
    localparam logic [ADDR_W-1:0] ADR_RELOAD   = 16'hD900;

    typedef logic [DATA_W-1:0]            byte_t;
    typedef logic [NREG-1:0][DATA_W-1:0]  regs_t;
    typedef logic [CNT_W-1:0]             cnt_t;
endpackage

// File: rtl/cbic_regfile.sv
module cbic_regfile
    import cbic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output regs_t             regs_o
);
    typedef struct packed {
        regs_t regs;
    } rf_state_t;

    rf_state_t s_d, s_q;
    logic      hit;

    always_comb begin
        s_d = s_q;
        hit = wr_en && addr[ADDR_W-1];
        if (hit) begin
            s_d.regs[addr[IDX_LSB +: IDX_W]] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs_o = s_q.regs;

    // R1: the addressed register holds the written byte one cycle later
    assert_reg_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1]) |=> regs_o[$past(addr[IDX_LSB +: IDX_W])] == $past(wdata));

    // R11: low-half writes and idle cycles leave the file untouched
    assert_low_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr[ADDR_W-1]) |=> $stable(regs_o));
endmodule

// File: rtl/cbic_bank_map.sv
module cbic_bank_map
    import cbic_pkg::*;
(
    input  regs_t                              regs,
    output logic [WRAM_WIN*WRAM_BANK_W-1:0]    wram_bank,
    output logic [PRG_WIN*PRG_BANK_W-1:0]      prg_bank,
    output logic [PRG_WIN-1:0]                 prg_ext,
    output logic                               chr_lo,
    output logic                               chr_hi,
    output logic                               mirror
);
    genvar gw;
    generate
        for (gw = 0; gw < WRAM_WIN; gw++) begin : g_wram
            byte_t r;
            assign r = regs[REG_WRAM0 + gw];
            assign wram_bank[gw*WRAM_BANK_W +: WRAM_BANK_W] =
                r[DATA_W-1:2] | {{(WRAM_BANK_W-1){1'b0}}, r[0]};
        end
        for (gw = 0; gw < PRG_WIN; gw++) begin : g_prg
            if (gw == PRG_WIN - 1) begin : g_fixed
                assign prg_bank[gw*PRG_BANK_W +: PRG_BANK_W] = {PRG_BANK_W{1'b1}};
                assign prg_ext[gw] = 1'b1;
            end else begin : g_sel
                byte_t r;
                assign r = regs[REG_PRG0 + gw];
                assign prg_bank[gw*PRG_BANK_W +: PRG_BANK_W] = r[PRG_BANK_W-1:0];
                assign prg_ext[gw] = r[PRG_CHIP_B];
            end
        end
    endgenerate

    assign chr_lo = regs[REG_CHR][0];
    assign chr_hi = 1'b1;
    assign mirror = ~regs[REG_MIRROR][1];
endmodule

// File: rtl/cbic_irq_timer.sv
module cbic_irq_timer
    import cbic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output logic              irq
);
    typedef struct packed {
        cnt_t latch;
        cnt_t count;
        logic en;
        logic saved;
        logic pend;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic wr_lo, wr_hi, wr_ack, wr_reload, wrap;

    always_comb begin
        s_d       = s_q;
        wr_lo     = wr_en && (addr == ADR_LATCH_LO);
        wr_hi     = wr_en && (addr == ADR_LATCH_HI);
        wr_ack    = wr_en && (addr == ADR_ACK);
        wr_reload = wr_en && (addr == ADR_RELOAD);
        wrap      = s_q.en && (s_q.count == {CNT_W{1'b1}});

        if (wr_lo) s_d.latch[DATA_W-1:0]     = wdata;
        if (wr_hi) s_d.latch[CNT_W-1:DATA_W] = wdata;

        if (wr_reload) begin
            s_d.count = s_q.latch;
            s_d.en    = wdata[1];
            s_d.saved = wdata[0];
            s_d.pend  = 1'b0;
        end else begin
            if (wr_ack) begin
                s_d.en   = s_q.saved;
                s_d.pend = 1'b0;
            end
            if (wrap) begin
                s_d.count = s_q.latch;
                s_d.pend  = 1'b1;
            end else if (s_q.en) begin
                s_d.count = s_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.pend;

    // R7: low latch byte follows its command write
    assert_latch_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> s_q.latch[DATA_W-1:0] == $past(wdata));

    // R8: reload command restarts counter and clears the request
    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> (s_q.count == $past(s_q.latch)) && !irq
                      && (s_q.en == $past(wdata[1])) && (s_q.saved == $past(wdata[0])));

    // R9: acknowledge restores enable from the saved copy
    assert_ack_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !wrap) |=> (s_q.en == $past(s_q.saved)) && !irq);

    // R10: a wrap reloads from the latch and raises the request
    assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && (s_q.count == {CNT_W{1'b1}}) && !wr_reload)
        |=> irq && (s_q.count == $past(s_q.latch)));

    // R10: the request is held until a command clears it
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ack && !wr_reload) |=> irq);
endmodule

// File: rtl/cart_bank_irq_ctrl.sv
module cart_bank_irq_ctrl
    import cbic_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_wr,
    input  logic [ADDR_W-1:0]                cpu_addr,
    input  logic [DATA_W-1:0]                cpu_wdata,
    output logic [WRAM_WIN*WRAM_BANK_W-1:0]  wram_bank_o,
    output logic [PRG_WIN*PRG_BANK_W-1:0]    prg_bank_o,
    output logic [PRG_WIN-1:0]               prg_ext_o,
    output logic                             chr_page_lo_o,
    output logic                             chr_page_hi_o,
    output logic                             mirror_o,
    output logic                             irq_o
);
    regs_t regs;

    cbic_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cpu_wr),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .regs_o (regs)
    );

    cbic_bank_map u_map (
        .regs      (regs),
        .wram_bank (wram_bank_o),
        .prg_bank  (prg_bank_o),
        .prg_ext   (prg_ext_o),
        .chr_lo    (chr_page_lo_o),
        .chr_hi    (chr_page_hi_o),
        .mirror    (mirror_o)
    );

    cbic_irq_timer u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .irq   (irq_o)
    );

    // R4: top program window never moves off the external last bank
    assert_top_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prg_ext_o[PRG_WIN-1] && (prg_bank_o[PRG_WIN*PRG_BANK_W-1 -: PRG_BANK_W] == {PRG_BANK_W{1'b1}}));
endmodule

// File: tb/tb_cart_bank_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [11:0] wram_bank_o;
    logic [23:0] prg_bank_o;
    logic [3:0]  prg_ext_o;
    logic        chr_page_lo_o, chr_page_hi_o, mirror_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cart_bank_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wram_bank_o(wram_bank_o), .prg_bank_o(prg_bank_o),
        .prg_ext_o(prg_ext_o), .chr_page_lo_o(chr_page_lo_o),
        .chr_page_hi_o(chr_page_hi_o), .mirror_o(mirror_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 wram", wram_bank_o, 0);
        check("R12 prg low windows", prg_bank_o[17:0], 0);
        check("R12 prg ext", prg_ext_o, 4'b1000);
        check("R12 mirror", mirror_o, 1);
        check("R12 chr lo", chr_page_lo_o, 0);
        check("R12 irq", irq_o, 0);
    endtask

    task automatic t_banks;
        cpu_write(16'h8000, 8'h85);              // R1, R2: 0x21|1
        cpu_write(16'hF100, 8'h0C);              // R1 upper nibble ignored
        check("R2 wram0", wram_bank_o[5:0], 6'h21);
        check("R1 wram1 via 0xF100", wram_bank_o[11:6], 6'h03);
        cpu_write(16'h8200, 8'h45);
        cpu_write(16'hA300, 8'h3F);
        cpu_write(16'h8400, 8'hC7);
        check("R3 prg0 bank", prg_bank_o[5:0], 6'h05);
        check("R3 prg1 bank", prg_bank_o[11:6], 6'h3F);
        check("R3 prg2 bank", prg_bank_o[17:12], 6'h07);
        check("R3 prg ext", prg_ext_o[2:0], 3'b101);
        check("R4 top bank", prg_bank_o[23:18], 6'h3F);
        check("R4 top ext", prg_ext_o[3], 1);
        cpu_write(16'h8A00, 8'h02);
        check("R5 mirror set", mirror_o, 0);
        cpu_write(16'h8A00, 8'hFD);
        check("R5 mirror clear", mirror_o, 1);
        cpu_write(16'h8500, 8'h01);
        check("R6 chr lo", chr_page_lo_o, 1);
        check("R6 chr hi", chr_page_hi_o, 1);
    endtask

    task automatic t_ignored;
        cpu_write(16'h6200, 8'h11);
        cpu_write(16'h7A00, 8'h02);
        check("R11 prg0 unchanged", prg_bank_o[5:0], 6'h05);
        check("R11 mirror unchanged", mirror_o, 1);
    endtask

    task automatic t_irq_oneshot;
        cpu_write(16'hD600, 8'hFD);              // R7
        cpu_write(16'hD700, 8'hFF);              // R7 latch = 0xFFFD
        cpu_write(16'hD900, 8'h02);              // R8 en=1 saved=0, count=FFFD
        check("R8 irq clear after reload", irq_o, 0);
        idle(2);
        check("R10 no irq before wrap", irq_o, 0);
        idle(1);
        check("R7 R10 irq on wrap", irq_o, 1);
        idle(5);
        check("R10 irq held", irq_o, 1);
        cpu_write(16'hD800, 8'h00);              // R9 saved=0 -> disabled
        check("R9 ack clears", irq_o, 0);
        idle(10);
        check("R9 disabled after ack", irq_o, 0);
    endtask

    task automatic t_irq_repeat;
        cpu_write(16'hD900, 8'h03);              // en=1 saved=1
        idle(3);
        check("R8 irq after restart", irq_o, 1);
        cpu_write(16'hD800, 8'h00);              // count now FFFE? ack at wrap+1
        check("R9 ack clears again", irq_o, 0);
        idle(4);
        check("R9 enable kept from saved", irq_o, 1);
        cpu_write(16'hD900, 8'h00);
        idle(8);
        check("R8 reload with enable 0", irq_o, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_banks();
        t_ignored();
        t_irq_oneshot();
        t_irq_repeat();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule